// File: doc/BRIEF.md
# Hardware Volume Button Counter

This block counts presses of the physical volume buttons on an audio controller. Two identical 3-bit counters sit side by side in one byte-wide status word. A volume-up event moves both counters up by one step. A volume-down event moves both down by one step. Neither counter ever wraps past its limit. A mute event leaves the counters alone. Every event of the three kinds raises an interrupt request, which stays high until software pulses a clear strobe.

Software reaches the status word through a small byte-wide register window of four aliased addresses. A read from any of the four returns the same byte. A write to any of the four, whatever the data, restores both counters to their mid value of 4. Software usually reads the byte after an interrupt, compares it with 0x88 to find the direction of the press, then writes to re-centre the counters and pulses the clear. A sticky mute flag lets software tell a mute press apart from an up or down press that was absorbed at a limit.

Top module: `hvol_btn_ctr`

## Requirements
- R1: After reset the status byte reads 0x88 (both counters at 4), irq is low and mute_flag is low.
- R2: A cycle with evt_up high and evt_down low adds one to both counters from the next cycle. Each counter occupies 3 bits: counter A in byte bits [3:1], counter B in bits [7:5]. A counter at 7 stays at 7, so the byte never goes past 0xEE. One press from reset reads 0xAA.
- R3: A cycle with evt_down high and evt_up low subtracts one from both counters. A counter at 0 stays at 0, so the byte never goes below 0x00. One press from reset reads 0x66.
- R4: When evt_up and evt_down are high in the same cycle, the counters hold their values.
- R5: Any cycle with evt_up, evt_down or evt_mute high sets irq in the next cycle. A mute event on its own leaves the status byte unchanged.
- R6: irq stays high until a cycle with irq_clr high. After that cycle irq is low, unless a button event arrives in that same cycle, in which case irq stays high.
- R7: mute_flag is set by an evt_mute cycle and cleared by an irq_clr cycle, with a mute event winning over a clear in the same cycle. Up and down events never set it.
- R8: A cycle with reg_wr high loads both counters with 4 (byte 0x88) for the next cycle, whatever the values of reg_wdata and reg_addr. The write takes priority over an up or down event in the same cycle, though that event still raises irq.
- R9: reg_rd_data is the same for all four values of reg_addr. Byte bits 0 and 4 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_up | input | 1 | Debounced volume-up press, one cycle per press |
| evt_down | input | 1 | Debounced volume-down press, one cycle per press |
| evt_mute | input | 1 | Debounced mute press, one cycle per press |
| reg_addr | input | 2 | Register window address, four aliases |
| reg_wr | input | 1 | Write strobe, re-centres both counters |
| reg_wdata | input | 8 | Write data, has no effect |
| reg_rd_data | output | 8 | Packed counter byte |
| irq_clr | input | 1 | Interrupt clear strobe |
| irq | output | 1 | Interrupt request, stays high until cleared |
| mute_flag | output | 1 | Sticky mute-event status |

## Verification
Two pairs of actions can fall in the same cycle. A register write can coincide with a button press, and an interrupt clear can coincide with a new press. In the first pair the write must win on the counters while the press still raises the interrupt. In the second the press must keep the interrupt high. The bench forces both pairs in directed steps and also draws them often in the random phase, where each strobe is set on its own with a fixed-seed probability. The bench judges each cycle against a model that takes the write as the override of the counters and takes the press as the set of the interrupt.

// File: rtl/hvol_pkg.sv
package hvol_pkg;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_INC  = 2'd1,
    STEP_DEC  = 2'd2,
    STEP_LOAD = 2'd3
  } step_e;

  // A load beats any step. Opposite steps cancel.
  function automatic step_e step_kind(logic inc, logic dec, logic load);
    if (load)              return STEP_LOAD;
    else if (inc && !dec)  return STEP_INC;
    else if (dec && !inc)  return STEP_DEC;
    else                   return STEP_HOLD;
  endfunction

  // Saturating next value on a 32-bit scale.
  function automatic int unsigned sat_next(int unsigned cur, step_e kind,
                                           int unsigned maxv, int unsigned initv);
    case (kind)
      STEP_LOAD: return initv;
      STEP_INC:  return (cur >= maxv) ? maxv : cur + 1;
      STEP_DEC:  return (cur == 0)    ? 0    : cur - 1;
      default:   return cur;
    endcase
  endfunction

endpackage

// File: rtl/hvol_sat_ctr.sv
module hvol_sat_ctr #(
  parameter int CTR_W    = 3,
  parameter int CTR_INIT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  hvol_pkg::step_e    step,
  output logic [CTR_W-1:0]   val
);
  localparam int unsigned MAXV = (1 << CTR_W) - 1;

  always_ff @(posedge clk) begin
    if (!rst_n) val <= CTR_W'(CTR_INIT);
    else        val <= CTR_W'(hvol_pkg::sat_next(32'(val), step, MAXV, CTR_INIT));
  end
endmodule

// File: rtl/hvol_irq_ctl.sv
module hvol_irq_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic press,
  input  logic mute,
  input  logic clr,
  output logic irq,
  output logic mute_flag
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq       <= 1'b0;
      mute_flag <= 1'b0;
    end else begin
      irq       <= press | (irq & ~clr);
      mute_flag <= mute  | (mute_flag & ~clr);
    end
  end
endmodule

// File: rtl/hvol_btn_ctr.sv
module hvol_btn_ctr #(
  parameter int CTR_W     = 3,
  parameter int NUM_CTR   = 2,
  parameter int CTR_INIT  = 4,
  parameter int NUM_ALIAS = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           evt_up,
  input  logic                           evt_down,
  input  logic                           evt_mute,
  input  logic [$clog2(NUM_ALIAS)-1:0]   reg_addr,
  input  logic                           reg_wr,
  input  logic [NUM_CTR*(CTR_W+1)-1:0]   reg_wdata,
  output logic [NUM_CTR*(CTR_W+1)-1:0]   reg_rd_data,
  input  logic                           irq_clr,
  output logic                           irq,
  output logic                           mute_flag
);
  localparam int SLOT_W = CTR_W + 1;
  localparam int DATA_W = NUM_CTR * SLOT_W;

  // Named events for the checker
  logic            press_any;
  hvol_pkg::step_e step_now;
  logic [DATA_W-1:0] status_word;
  logic [DATA_W-1:0] alias_view [NUM_ALIAS];

  // The write data carries no meaning: any write re-centres the counters.
  logic unused_wdata;
  assign unused_wdata = ^reg_wdata;

  assign press_any = evt_up | evt_down | evt_mute;
  assign step_now  = hvol_pkg::step_kind(evt_up, evt_down, reg_wr);

  genvar g;
  generate
    for (g = 0; g < NUM_CTR; g++) begin : g_ctr
      logic [CTR_W-1:0] val;
      hvol_sat_ctr #(.CTR_W(CTR_W), .CTR_INIT(CTR_INIT)) ctr_i (
        .clk  (clk),
        .rst_n(rst_n),
        .step (step_now),
        .val  (val)
      );
      // Slot layout: bit 0 of each slot is a constant zero, the counter sits above it.
      assign status_word[g*SLOT_W]                  = 1'b0;
      assign status_word[g*SLOT_W+1 +: CTR_W]       = val;
    end
    for (g = 0; g < NUM_ALIAS; g++) begin : g_alias
      assign alias_view[g] = status_word;
    end
  endgenerate

  assign reg_rd_data = alias_view[reg_addr];

  hvol_irq_ctl irq_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .press    (press_any),
    .mute     (evt_mute),
    .clr      (irq_clr),
    .irq      (irq),
    .mute_flag(mute_flag)
  );
endmodule

// File: rtl/hvol_btn_ctr_chk.sv
module hvol_btn_ctr_chk #(
  parameter int CTR_W     = 3,
  parameter int NUM_CTR   = 2,
  parameter int CTR_INIT  = 4,
  parameter int NUM_ALIAS = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         evt_up,
  input logic                         evt_down,
  input logic                         evt_mute,
  input logic                         reg_wr,
  input logic                         irq_clr,
  input logic                         press_any,
  input logic [NUM_CTR*(CTR_W+1)-1:0] reg_rd_data,
  input logic                         irq,
  input logic                         mute_flag
);
  localparam int SLOT_W = CTR_W + 1;
  localparam int DATA_W = NUM_CTR * SLOT_W;

  function automatic logic [DATA_W-1:0] fill_word(int unsigned c);
    logic [DATA_W-1:0] w;
    w = '0;
    for (int k = 0; k < NUM_CTR; k++) w[k*SLOT_W+1 +: CTR_W] = CTR_W'(c);
    return w;
  endfunction

  function automatic logic [DATA_W-1:0] gap_mask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int k = 0; k < NUM_CTR; k++) m[k*SLOT_W] = 1'b1;
    return m;
  endfunction

  localparam logic [DATA_W-1:0] INIT_WORD = fill_word(CTR_INIT);
  localparam logic [DATA_W-1:0] MAX_WORD  = fill_word((1 << CTR_W) - 1);
  localparam logic [DATA_W-1:0] GAP_MASK  = gap_mask();

  // R2
  up_saturates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_data == MAX_WORD && evt_up && !evt_down && !reg_wr) |=> reg_rd_data == MAX_WORD);

  // R3
  down_saturates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_data == '0 && evt_down && !evt_up && !reg_wr) |=> reg_rd_data == '0);

  // R4
  cancel_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_up && evt_down && !reg_wr) |=> $stable(reg_rd_data));

  // R5
  press_raises_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    press_any |=> irq);

  // R5
  mute_keeps_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_mute && !evt_up && !evt_down && !reg_wr) |=> $stable(reg_rd_data));

  // R6
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);

  // R6
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!press_any && (irq_clr || !irq)) |=> !irq);

  // R7
  mute_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_mute |=> mute_flag);

  // R8
  write_recentres_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> reg_rd_data == INIT_WORD);

  // R9
  gap_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_data & GAP_MASK) == '0);
endmodule

bind hvol_btn_ctr hvol_btn_ctr_chk #(
  .CTR_W(CTR_W), .NUM_CTR(NUM_CTR), .CTR_INIT(CTR_INIT), .NUM_ALIAS(NUM_ALIAS)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .evt_up     (evt_up),
  .evt_down   (evt_down),
  .evt_mute   (evt_mute),
  .reg_wr     (reg_wr),
  .irq_clr    (irq_clr),
  .press_any  (press_any),
  .reg_rd_data(reg_rd_data),
  .irq        (irq),
  .mute_flag  (mute_flag)
);

// File: tb/hvol_btn_ctr_tb_top.sv
`timescale 1ns/1ps
module hvol_btn_ctr_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       evt_up = 1'b0, evt_down = 1'b0, evt_mute = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rd_data;
  logic       irq_clr = 1'b0;
  logic       irq, mute_flag;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // reference state
  int m_cnt = 4;
  bit m_irq = 1'b0;
  bit m_mute = 1'b0;

  always #5 clk = ~clk;

  hvol_btn_ctr dut_i (
    .clk(clk), .rst_n(rst_n), .evt_up(evt_up), .evt_down(evt_down),
    .evt_mute(evt_mute), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd_data(reg_rd_data), .irq_clr(irq_clr),
    .irq(irq), .mute_flag(mute_flag)
  );

  // Byte image of a counter value placed in both 3-bit fields.
  function automatic logic [7:0] word_of(int c);
    logic [2:0] f;
    f = c[2:0];
    return {f, 1'b0, f, 1'b0};
  endfunction

  task automatic check(string tag, string what, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%02h expected 0x%02h", tag, what, act, exp);
    end
  endtask

  // Drive one cycle at the falling edge, update the model, check after the rising edge.
  task automatic step(string tag, bit up, bit dn, bit mu, bit wr, bit clr,
                      logic [1:0] addr, logic [7:0] wd);
    @(negedge clk);
    evt_up = up; evt_down = dn; evt_mute = mu;
    reg_wr = wr; irq_clr = clr; reg_addr = addr; reg_wdata = wd;
    if (wr)               m_cnt = 4;
    else if (up && !dn)   m_cnt = (m_cnt < 7) ? m_cnt + 1 : 7;
    else if (dn && !up)   m_cnt = (m_cnt > 0) ? m_cnt - 1 : 0;
    m_irq  = up || dn || mu || (m_irq && !clr);
    m_mute = mu || (m_mute && !clr);
    @(posedge clk);
    #1;
    evt_up = 0; evt_down = 0; evt_mute = 0; reg_wr = 0; irq_clr = 0;
    check(tag, "byte", reg_rd_data, word_of(m_cnt));
    check(tag, "irq", {7'd0, irq}, {7'd0, m_irq});
    check(tag, "mute_flag", {7'd0, mute_flag}, {7'd0, m_mute});
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    check("R1", "byte", reg_rd_data, 8'h88);
    check("R1", "irq", {7'd0, irq}, 8'd0);
    check("R1", "mute_flag", {7'd0, mute_flag}, 8'd0);

    step("R2", 1, 0, 0, 0, 0, 2'd0, 8'h00);
    check("R2", "one up", reg_rd_data, 8'hAA);
    step("R6", 0, 0, 0, 0, 1, 2'd0, 8'h00);
    step("R8", 0, 0, 0, 1, 0, 2'd2, 8'h13);
    step("R3", 0, 1, 0, 0, 0, 2'd1, 8'h00);
    check("R3", "one down", reg_rd_data, 8'h66);
    // R3 saturation at zero
    for (int i = 0; i < 6; i++) step("R3", 0, 1, 0, 0, 0, 2'd0, 8'h00);
    // R2 saturation at seven
    for (int i = 0; i < 9; i++) step("R2", 1, 0, 0, 0, 0, 2'd3, 8'h00);
    check("R2", "ceiling", reg_rd_data, 8'hEE);
    step("R4", 1, 1, 0, 0, 0, 2'd0, 8'h00);
    step("R6", 0, 0, 0, 0, 1, 2'd0, 8'h00);
    step("R5", 0, 0, 1, 0, 0, 2'd0, 8'h00);
    step("R7", 0, 0, 0, 0, 1, 2'd0, 8'h00);
    step("R6", 1, 0, 0, 0, 1, 2'd0, 8'h00);
    step("R8", 0, 1, 0, 1, 0, 2'd1, 8'hFF);
    step("R7", 0, 0, 1, 0, 1, 2'd0, 8'h00);
    // R9 all aliases equal, gap bits clear
    step("R2", 1, 0, 0, 0, 0, 2'd0, 8'h00);
    for (int a = 0; a < 4; a++) begin
      reg_addr = a[1:0];
      #1;
      check("R9", "alias", reg_rd_data, word_of(m_cnt));
      check("R9", "gap bits", reg_rd_data & 8'h11, 8'h00);
    end

    void'($urandom(32'd2718));
    for (int i = 0; i < 600; i++) begin
      bit up, dn, mu, wr, clr;
      string tag;
      up  = ($urandom % 3) == 0;
      dn  = ($urandom % 3) == 0;
      mu  = ($urandom % 6) == 0;
      wr  = ($urandom % 8) == 0;
      clr = ($urandom % 4) == 0;
      tag = wr ? "R8" : (up && dn) ? "R4" : up ? "R2" : dn ? "R3" : mu ? "R5" : "R6";
      step(tag, up, dn, mu, wr, clr, 2'($urandom), 8'($urandom));
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule